// File: doc/BRIEF.md
# Multicast Group Hash Filter

This block makes the receive-side address decision for a MAC. For each frame the host side of the datapath presents the 48-bit destination address with a one-cycle valid strobe. One cycle later the block returns a registered accept or reject decision together with a matching valid pulse.

Group-addressed frames are looked up in a 64-bit hash table. The index is not a CRC. It is the upper six bits of the final address byte. Individually addressed frames skip the table and pass only when they equal the programmed station address.

The table is written as two 32-bit words. Two single-cycle operations also act on it. A clear empties the table except for the broadcast bit. A fill opens every bit.

Top module: `mgh_filter`

## Requirements
- R1: After reset `pass_valid_o` and `pass_o` are 0, and the table is in the cleared state described in R6.
- R2: `pass_valid_o` is high exactly one cycle after each cycle with `da_valid_i` high. `pass_o` is 0 whenever `pass_valid_o` is 0.
- R3: Address byte k occupies `da_i[8k+7:8k]`, with byte 0 the first byte. A frame is group-addressed when `da_i[0]` is 1. Its index is `da_i[47:42]`, that is byte 5 shifted right by two. It passes exactly when the table bit at that index is 1.
- R4: A write with `tbl_wr_lo_i` loads `tbl_wdata_i` into table bits 31..0. A write with `tbl_wr_hi_i` loads it into table bits 63..32. Each write leaves the other word unchanged.
- R5: The all-ones broadcast address uses index 63. It passes only when table bit 63 (bit 31 of the high word) is 1.
- R6: `tbl_clear_i` sets the low word to 0x00000000 and the high word to 0x80000000. After a clear, broadcasts still pass and every other group index is rejected.
- R7: `tbl_fill_i` sets both words to 0xffffffff, so every group address passes.
- R8: An address with `da_i[0]` = 0 passes exactly when it equals `sta_addr_i`. The table contents have no effect on it.
- R9: A frame strobed in the same cycle as a table operation is decided with the table as it was before that operation. The operation applies from the next frame on.
- R10: When table operations coincide, clear wins over fill, and fill wins over word writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_wr_lo_i | input | 1 | Load low table word from `tbl_wdata_i` |
| tbl_wr_hi_i | input | 1 | Load high table word from `tbl_wdata_i` |
| tbl_wdata_i | input | 32 | Table word write data |
| tbl_clear_i | input | 1 | Clear table, keep broadcast bit |
| tbl_fill_i | input | 1 | Set every table bit |
| sta_addr_i | input | 48 | Station address for individual frames |
| da_i | input | 48 | Destination address of the frame |
| da_valid_i | input | 1 | Destination address strobe |
| pass_o | output | 1 | Frame accepted |
| pass_valid_o | output | 1 | Decision valid, one cycle after strobe |

## Verification
The bench goes after the word split at indices 31 and 32. A design that swapped or misaligned the halves would accept the wrong neighbour. It also covers broadcast under a cleared, an emptied and a filled table, and a design that special-cased broadcast instead of indexing bit 63 would pass a frame whose top bit is 0. Individual addresses are sent against a fully filled table and with a single changed byte. A design that let them reach the table, or compared only part of the address, would accept them. Same-cycle write and strobe, and stacked clear, fill and write operations, expose a design that reads the table after the update or that orders the operations wrongly.

// File: rtl/mgh_pkg.sv
package mgh_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WORD  = 2'd1,
    OP_FILL  = 2'd2,
    OP_CLEAR = 2'd3
  } tbl_op_e;

  function automatic tbl_op_e pick_op(input logic clear, input logic fill,
                                      input logic wr);
    if (clear)     return OP_CLEAR;
    else if (fill) return OP_FILL;
    else if (wr)   return OP_WORD;
    return OP_NONE;
  endfunction
endpackage

// File: rtl/mgh_table.sv
module mgh_table
  import mgh_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_lo_i,
  input  logic                  wr_hi_i,
  input  logic [WORD_W-1:0]     wdata_i,
  input  logic                  clear_i,
  input  logic                  fill_i,
  output logic [2*WORD_W-1:0]   tbl_o
);
  localparam int NWORDS = 2;
  localparam logic [WORD_W-1:0] TOP_BIT = {1'b1, {(WORD_W-1){1'b0}}};

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam logic [WORD_W-1:0] CLR_VAL = (w == NWORDS-1) ? TOP_BIT : '0;
    logic        wr;
    tbl_op_e     op;
    logic [WORD_W-1:0] q;

    assign wr = (w == 0) ? wr_lo_i : wr_hi_i;
    assign op = pick_op(clear_i, fill_i, wr);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= CLR_VAL;
      else begin
        unique case (op)
          OP_CLEAR: q <= CLR_VAL;
          OP_FILL:  q <= '1;
          OP_WORD:  q <= wdata_i;
          default:  q <= q;
        endcase
      end
    end

    assign tbl_o[w*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/mgh_classify.sv
module mgh_classify #(
  parameter int ADDR_W = 48,
  parameter int TBL_W  = 64
) (
  input  logic [ADDR_W-1:0] da_i,
  input  logic [ADDR_W-1:0] sta_i,
  input  logic [TBL_W-1:0]  tbl_i,
  output logic              hit_o
);
  localparam int IDX_W = $clog2(TBL_W);

  logic             is_group;
  logic [IDX_W-1:0] idx;

  assign is_group = da_i[0];
  assign idx      = da_i[ADDR_W-1 -: IDX_W];

  always_comb begin
    if (is_group) hit_o = tbl_i[idx];
    else          hit_o = (da_i == sta_i);
  end
endmodule

// File: rtl/mgh_decide.sv
module mgh_decide (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic hit_i,
  output logic pass_o,
  output logic vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_o <= 1'b0;
      vld_o  <= 1'b0;
    end else begin
      pass_o <= vld_i & hit_i;
      vld_o  <= vld_i;
    end
  end
endmodule

// File: rtl/mgh_filter.sv
module mgh_filter #(
  parameter int ADDR_W = 48,
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_wr_lo_i,
  input  logic              tbl_wr_hi_i,
  input  logic [WORD_W-1:0] tbl_wdata_i,
  input  logic              tbl_clear_i,
  input  logic              tbl_fill_i,
  input  logic [ADDR_W-1:0] sta_addr_i,
  input  logic [ADDR_W-1:0] da_i,
  input  logic              da_valid_i,
  output logic              pass_o,
  output logic              pass_valid_o
);
  localparam int TBL_W = 2 * WORD_W;

  logic [TBL_W-1:0] tbl_q;
  logic             hit;

  mgh_table #(.WORD_W(WORD_W)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (tbl_wr_lo_i),
    .wr_hi_i (tbl_wr_hi_i),
    .wdata_i (tbl_wdata_i),
    .clear_i (tbl_clear_i),
    .fill_i  (tbl_fill_i),
    .tbl_o   (tbl_q)
  );

  mgh_classify #(.ADDR_W(ADDR_W), .TBL_W(TBL_W)) u_classify (
    .da_i  (da_i),
    .sta_i (sta_addr_i),
    .tbl_i (tbl_q),
    .hit_o (hit)
  );

  mgh_decide u_decide (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (da_valid_i),
    .hit_i  (hit),
    .pass_o (pass_o),
    .vld_o  (pass_valid_o)
  );
endmodule

// File: rtl/mgh_filter_chk.sv
module mgh_filter_chk #(
  parameter int ADDR_W = 48,
  parameter int WORD_W = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tbl_clear_i,
  input logic                  tbl_fill_i,
  input logic [ADDR_W-1:0]     sta_addr_i,
  input logic [ADDR_W-1:0]     da_i,
  input logic                  da_valid_i,
  input logic                  pass_o,
  input logic                  pass_valid_o,
  input logic [2*WORD_W-1:0]   tbl_q
);
  localparam logic [2*WORD_W-1:0] CLR_TBL = {1'b1, {(2*WORD_W-1){1'b0}}};

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (pass_valid_o == $past(da_valid_i))); // R2

  AST_PASS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pass_valid_o |-> !pass_o); // R2

  AST_UNICAST_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(da_valid_i) && !$past(da_i[0]))
      |-> (pass_o == ($past(da_i) == $past(sta_addr_i)))); // R8

  AST_BCAST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(da_valid_i) && ($past(da_i) == {ADDR_W{1'b1}}))
      |-> (pass_o == $past(tbl_q[2*WORD_W-1]))); // R5

  AST_CLEAR_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(tbl_clear_i)) |-> (tbl_q == CLR_TBL)); // R6

  AST_FILL_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(tbl_fill_i) && !$past(tbl_clear_i)) |-> (&tbl_q)); // R7
endmodule

bind mgh_filter mgh_filter_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/mgh_filter_test.sv
module mgh_filter_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tbl_wr_lo_i = 1'b0;
  logic        tbl_wr_hi_i = 1'b0;
  logic [31:0] tbl_wdata_i = '0;
  logic        tbl_clear_i = 1'b0;
  logic        tbl_fill_i = 1'b0;
  logic [47:0] sta_addr_i = 48'h66_55_44_33_22_02;
  logic [47:0] da_i = '0;
  logic        da_valid_i = 1'b0;
  logic        pass_o;
  logic        pass_valid_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] mdl;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  mgh_filter uut (.*);

  always #10 clk_i = ~clk_i;

  localparam int NV = 10;
  localparam logic [47:0] VEC [NV] = '{
    {6'd0,  2'b10, 32'h1234_5678, 8'h01},
    {6'd1,  2'b00, 32'h0000_0000, 8'h03},
    {6'd2,  2'b11, 32'hDEAD_BEEF, 8'h01},
    {6'd8,  2'b01, 32'h0A0B_0C0D, 8'h05},
    {6'd31, 2'b10, 32'h1111_2222, 8'h01},
    {6'd32, 2'b10, 32'h3333_4444, 8'h01},
    {6'd44, 2'b00, 32'h5555_6666, 8'h07},
    {6'd63, 2'b00, 32'h7777_8888, 8'h01},
    48'h66_55_44_33_22_02,
    48'h66_55_44_33_23_02
  };

  function automatic logic [47:0] grp(input logic [5:0] idx);
    return {idx, 2'b10, 32'hCAFE_0123, 8'h01};
  endfunction

  function automatic logic model_pass(input logic [47:0] a);
    if (a[0]) return mdl[a[47:42]];
    return a == sta_addr_i;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] a, input logic exp, input string req);
    @(negedge clk_i);
    da_i = a; da_valid_i = 1'b1;
    @(negedge clk_i);
    da_valid_i = 1'b0;
    chk({req, " valid"}, pass_valid_o, 1'b1);
    chk(req, pass_o, exp);
  endtask

  task automatic wr_word(input logic hi, input logic [31:0] d);
    @(negedge clk_i);
    tbl_wr_lo_i = ~hi; tbl_wr_hi_i = hi; tbl_wdata_i = d;
    if (hi) mdl[63:32] = d; else mdl[31:0] = d;
    @(negedge clk_i);
    tbl_wr_lo_i = 1'b0; tbl_wr_hi_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    mdl = {32'h8000_0000, 32'h0};
    repeat (3) @(negedge clk_i);
    // R1: reset outputs
    chk("R1 reset pass", pass_o, 1'b0);
    chk("R1 reset valid", pass_valid_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle valid", pass_valid_o, 1'b0);
    send(BCAST, 1'b1, "R1 reset table bcast");
    send(grp(6'd5), 1'b0, "R1 reset table group");

    // R2: no valid without strobe
    @(negedge clk_i);
    chk("R2 no strobe valid", pass_valid_o, 1'b0);
    chk("R2 no strobe pass", pass_o, 1'b0);

    // R3/R8: vector table against a pattern
    wr_word(1'b0, 32'hA5A5_0F0F);
    wr_word(1'b1, 32'h8001_1234);
    for (int i = 0; i < NV; i++)
      send(VEC[i], model_pass(VEC[i]), "R3 R8 vector");

    // R4: word split at 31/32
    wr_word(1'b0, 32'h8000_0008);
    wr_word(1'b1, 32'h0000_0000);
    send(grp(6'd3),  1'b1, "R4 low bit 3");
    send(grp(6'd35), 1'b0, "R4 high bit 3 unset");
    send(grp(6'd31), 1'b1, "R4 low bit 31");
    send(grp(6'd32), 1'b0, "R4 high bit 0 unset");
    // R5: broadcast with bit 63 clear
    send(BCAST, 1'b0, "R5 bcast bit63 clear");
    wr_word(1'b1, 32'h0000_0008);
    send(grp(6'd35), 1'b1, "R4 high bit 3");
    send(grp(6'd3),  1'b1, "R4 low kept");
    send(BCAST, 1'b0, "R5 bcast still clear");

    // R7: fill; R8 unicast unaffected by table
    @(negedge clk_i); tbl_fill_i = 1'b1; mdl = '1;
    @(negedge clk_i); tbl_fill_i = 1'b0;
    send(grp(6'd17), 1'b1, "R7 fill group");
    send(BCAST, 1'b1, "R5 R7 bcast after fill");
    send(48'h66_55_44_33_22_00, 1'b0, "R8 unicast mismatch full table");
    send(48'h67_55_44_33_22_02, 1'b0, "R8 unicast last byte differs");
    send(sta_addr_i, 1'b1, "R8 unicast match");

    // R6: clear
    @(negedge clk_i); tbl_clear_i = 1'b1; mdl = {32'h8000_0000, 32'h0};
    @(negedge clk_i); tbl_clear_i = 1'b0;
    send(grp(6'd17), 1'b0, "R6 clear group");
    send(grp(6'd62), 1'b0, "R6 clear idx 62");
    send(BCAST, 1'b1, "R6 clear bcast");

    // R9: same-cycle write and strobe
    @(negedge clk_i);
    da_i = grp(6'd4); da_valid_i = 1'b1;
    tbl_wr_lo_i = 1'b1; tbl_wdata_i = 32'h0000_0010;
    @(negedge clk_i);
    da_valid_i = 1'b0; tbl_wr_lo_i = 1'b0;
    chk("R9 old table used", pass_o, 1'b0);
    send(grp(6'd4), 1'b1, "R9 new table next frame");

    // R10: priority
    @(negedge clk_i);
    tbl_clear_i = 1'b1; tbl_fill_i = 1'b1; tbl_wr_hi_i = 1'b1; tbl_wdata_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    tbl_clear_i = 1'b0; tbl_fill_i = 1'b0; tbl_wr_hi_i = 1'b0;
    send(grp(6'd40), 1'b0, "R10 clear beats fill/write");
    send(BCAST, 1'b1, "R10 clear bcast kept");
    @(negedge clk_i);
    tbl_fill_i = 1'b1; tbl_wr_lo_i = 1'b1; tbl_wdata_i = 32'h0;
    @(negedge clk_i);
    tbl_fill_i = 1'b0; tbl_wr_lo_i = 1'b0;
    send(grp(6'd0), 1'b1, "R10 fill beats write");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule